// File: doc/BRIEF.md
# Selectable-Width Serial/Parallel Line Gearbox

This block sits between a bit-serial line and a framer's parallel word port. It works in both directions on a single line-rate clock. On transmit it takes parallel words and sends them out one bit per clock. On receive it gathers line bits into words.

Three modes are chosen at runtime: serial pass-through, 4-bit words and 8-bit words. The word clock is never a separate clock. It is a one-cycle enable that repeats every 4 or 8 line cycles, so the framer logic can share the line clock.

The mode pins are sampled only while the synchronous reset is high. A new mode therefore starts from a clean word boundary.

Top module: `lineGearbox`

## Requirements
- R1: The mode inputs (`parModeIn` and `wideIn`) are captured only while `rst` is high. Changing them while `rst` is low changes nothing at the outputs. Releasing `rst` restarts word alignment at bit 0.
- R2: Serial mode is selected by `parModeIn`=0, and `wideIn` is then ignored. In this mode:
  - `txLine` equals `txSerIn` from one cycle earlier.
  - `rxSerOut` equals `rxSerIn` from one cycle earlier.
  - `txWordEn` is 1 on every cycle.
  - `rxWordValid` is 1 on every cycle after the first.
  - `rxWord` stays 0.
- R2 also covers parallel mode: there, `rxSerOut` stays 0.
- R3: Parallel mode is selected by `parModeIn`=1. The word length N is 8 when `wideIn`=1 and 4 when `wideIn`=0. `txWordEn` is high for exactly one cycle in every N. Counting the first cycle after reset release as cycle 0, it is high in cycles N-1, 2N-1, and so on.
- R4: In parallel mode, `txWord` is sampled in each cycle where `txWordEn` is high. Its bits appear on `txLine` from the next cycle onward, most significant used bit first: bit 7 for N=8, bit 3 for N=4. The output stream has no gap between words. `txLine` is 0 until the first sampled word starts.
- R5: With N=4, `txWord[7:4]` have no effect on `txLine`.
- R6: In parallel mode, `rxWord` is loaded from the last N received bits, with the earliest of them on the most significant used bit (bit 7 or bit 3). `rxWordValid` is high for the single cycle right after each load, in cycles N, 2N, and so on.
- R7: With N=4, `rxWord[7:4]` are always 0.
- R8: `rxWord` holds its value in every cycle where `rxWordValid` is low.
- R9: While `rst` is high, `txLine`, `rxWord`, `rxWordValid` and `rxSerOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock |
| rst | input | 1 | Synchronous reset, active high; also latches the mode |
| parModeIn | input | 1 | 1 = parallel word mode, 0 = serial pass-through |
| wideIn | input | 1 | 1 = 8-bit words, 0 = 4-bit words (parallel mode only) |
| txWord | input | WORD_W (8) | Parallel transmit word from the framer |
| txSerIn | input | 1 | Serial transmit bit (serial mode) |
| rxSerIn | input | 1 | Received line bit |
| txLine | output | 1 | Transmitted line bit |
| txWordEn | output | 1 | Transmit word-clock enable; `txWord` is sampled when high |
| rxWord | output | WORD_W (8) | Received parallel word |
| rxWordValid | output | 1 | One-cycle strobe marking a new `rxWord` |
| rxSerOut | output | 1 | Received bit passed through (serial mode) |

## Verification
The embedded assertions check these properties on every cycle:
- the bit counter stays within the word bound, and the word enable never repeats on two consecutive cycles;
- the latched mode is frozen outside reset;
- the receive word holds between strobes, and its upper half stays 0 in 4-bit mode;
- serial pass-through delays by one cycle;
- the first transmitted bit after each load is the correct MSB.

Only the bench's scenarios can show the rest:
- the full order of all bits in each transmit and receive word, and the stream having no gap across word boundaries;
- the exact phase of the first enable after reset;
- that toggling the mode pins mid-run leaves the outputs unaffected.

// File: rtl/gbPkg.sv
package gbPkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic serial;   // latched mode: bit-serial pass-through
    logic wide;     // latched mode: full-width words (parallel only)
    logic lastBit;  // current cycle carries the last bit of a word
  } gbStrobeT;
endpackage

// File: rtl/gbControl.sv
module gbControl
  import gbPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     parModeIn,
  input  logic     wideIn,
  output gbStrobeT strb
);
  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(HALF_W - 1);

  logic             serialQ;
  logic             wideQ;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             lastBit;

  // Mode is only sampled while in reset
  always_ff @(posedge clk) begin
    if (rst) begin
      serialQ <= ~parModeIn;
      wideQ   <= parModeIn & wideIn;
    end
  end

  assign lastIdx = wideQ ? LAST_WIDE : LAST_NARROW;
  assign lastBit = ~serialQ & (bitCnt == lastIdx);

  always_ff @(posedge clk) begin
    if (rst || serialQ || lastBit) bitCnt <= '0;
    else                           bitCnt <= bitCnt + 1'b1;
  end

  assign strb.serial  = serialQ;
  assign strb.wide    = wideQ;
  assign strb.lastBit = lastBit;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= lastIdx) else $error("bit counter past word end"); // R3

  AST_ENABLE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strb.lastBit |=> !strb.lastBit) else $error("word enable repeated"); // R3

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(serialQ) && $stable(wideQ))) else $error("mode moved outside reset"); // R1
endmodule

// File: rtl/gbDatapath.sv
module gbDatapath
  import gbPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  gbStrobeT          strb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txSerIn,
  input  logic              rxSerIn,
  output logic              txLine,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxWordValid,
  output logic              rxSerOut
);
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] txSh;
  logic [WORD_W-1:0] txLoad;
  logic [WORD_W-2:0] rxSh;
  logic [WORD_W-1:0] rxFull;
  logic [WORD_W-1:0] rxPick;

  // Narrow words are left-justified so the same MSB tap serves both widths
  assign txLoad = strb.wide ? txWord : {txWord[HALF_W-1:0], {HALF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)               txSh <= '0;
    else if (strb.serial)  txSh <= {txSerIn, {(WORD_W-1){1'b0}}};
    else if (strb.lastBit) txSh <= txLoad;
    else                   txSh <= {txSh[WORD_W-2:0], 1'b0};
  end
  assign txLine = txSh[WORD_W-1];

  // Receive: earliest bit ends up highest
  assign rxFull = {rxSh, rxSerIn};
  assign rxPick = strb.wide ? rxFull : {{HALF_W{1'b0}}, rxFull[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rxSh        <= '0;
      rxWord      <= '0;
      rxWordValid <= 1'b0;
      rxSerOut    <= 1'b0;
    end else begin
      rxSh        <= rxFull[WORD_W-2:0];
      rxWordValid <= strb.serial | strb.lastBit;
      rxSerOut    <= strb.serial & rxSerIn;
      if (strb.lastBit) rxWord <= rxPick;
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rxWordValid |-> $stable(rxWord)) else $error("rx word moved without strobe"); // R8

  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!strb.serial && !strb.wide) |-> (rxWord[WORD_W-1:HALF_W] == '0)) else $error("upper rx bits set"); // R7

  AST_SER_PASS: assert property (@(posedge clk) disable iff (rst)
    strb.serial |=> (txLine == $past(txSerIn))) else $error("serial tx path wrong"); // R2

  AST_TX_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    strb.lastBit |=> (txLine == (strb.wide ? $past(txWord[WORD_W-1]) : $past(txWord[HALF_W-1]))))
    else $error("first tx bit not MSB"); // R4
endmodule

// File: rtl/lineGearbox.sv
module lineGearbox
  import gbPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              parModeIn,
  input  logic              wideIn,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txSerIn,
  input  logic              rxSerIn,
  output logic              txLine,
  output logic              txWordEn,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxWordValid,
  output logic              rxSerOut
);
  gbStrobeT strb;

  gbControl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rst(rst), .parModeIn(parModeIn), .wideIn(wideIn), .strb(strb)
  );

  gbDatapath #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rst(rst), .strb(strb), .txWord(txWord), .txSerIn(txSerIn),
    .rxSerIn(rxSerIn), .txLine(txLine), .rxWord(rxWord),
    .rxWordValid(rxWordValid), .rxSerOut(rxSerOut)
  );

  assign txWordEn = strb.serial | strb.lastBit;
endmodule

// File: tb/sim_lineGearbox.sv
module sim_lineGearbox;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       parModeIn = 1'b1;
  logic       wideIn = 1'b1;
  logic [7:0] txWord = '0;
  logic       txSerIn = 1'b0;
  logic       rxSerIn = 1'b0;
  logic       txLine, txWordEn, rxWordValid, rxSerOut;
  logic [7:0] rxWord;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  lineGearbox #(.WORD_W(8)) u0 (
    .clk(clk), .rst(rst), .parModeIn(parModeIn), .wideIn(wideIn),
    .txWord(txWord), .txSerIn(txSerIn), .rxSerIn(rxSerIn),
    .txLine(txLine), .txWordEn(txWordEn), .rxWord(rxWord),
    .rxWordValid(rxWordValid), .rxSerOut(rxSerOut)
  );

  task automatic chk(input string tag, input string what, input int act, input int expv);
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Reference model state
  bit   lSer, lWide;
  int   wordLen;
  bit   txQ[$];
  bit   rxQ[$];
  bit   eTx, eRxSer, eValid;
  logic [7:0] eRxWord;

  task automatic runCase(input bit p, input bit w, input int cycles, input int flipAt);
    string base, pre;
    @(negedge clk);
    rst = 1'b1; parModeIn = p; wideIn = w;
    @(negedge clk);
    @(negedge clk);
    // R9: outputs cleared while reset is held
    chk("R9", "txLine", txLine, 0);
    chk("R9", "rxWord", rxWord, 0);
    chk("R9", "rxWordValid", rxWordValid, 0);
    chk("R9", "rxSerOut", rxSerOut, 0);
    lSer = !p; lWide = p & w; wordLen = lWide ? 8 : 4;
    txQ.delete(); rxQ.delete();
    eTx = 0; eRxSer = 0; eValid = 0; eRxWord = '0;
    rst = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      if (c > 0) @(negedge clk);
      if (c == flipAt) begin parModeIn = ~parModeIn; wideIn = ~wideIn; end
      pre = (flipAt >= 0 && c >= flipAt) ? "R1 " : "";
      // compare outputs for cycle c
      base = lSer ? "R2" : "R3";
      chk({pre, base}, "txWordEn", txWordEn, int'(lSer || (c % wordLen == wordLen - 1)));
      base = lSer ? "R2" : (lWide ? "R4" : "R5");
      chk({pre, base}, "txLine", txLine, eTx);
      chk({pre, "R2"}, "rxSerOut", rxSerOut, eRxSer);
      base = lSer ? "R2" : "R6";
      chk({pre, base}, "rxWordValid", rxWordValid, eValid);
      base = lSer ? "R2" : (!eValid ? "R8" : (lWide ? "R6" : "R7"));
      chk({pre, base}, "rxWord", rxWord, eRxWord);
      // drive inputs for cycle c
      txWord  = 8'($urandom);
      txSerIn = 1'($urandom);
      rxSerIn = 1'($urandom);
      // advance model to cycle c+1
      if (lSer) begin
        eTx = txSerIn; eRxSer = rxSerIn; eValid = 1; eRxWord = '0;
      end else begin
        eRxSer = 0;
        if (c % wordLen == wordLen - 1)
          for (int b = wordLen - 1; b >= 0; b--) txQ.push_back(txWord[b]);
        eTx = (txQ.size() > 0) ? txQ.pop_front() : 1'b0;
        rxQ.push_back(rxSerIn);
        if (c % wordLen == wordLen - 1) begin
          eRxWord = '0;
          for (int b = 0; b < wordLen; b++) eRxWord[wordLen - 1 - b] = rxQ[b];
          rxQ.delete();
          eValid = 1;
        end else begin
          eValid = 0;
        end
      end
    end
  endtask

  initial begin
    runCase(1'b1, 1'b1, 70, -1);  // 8-bit words
    runCase(1'b1, 1'b0, 50, -1);  // 4-bit words
    runCase(1'b0, 1'b0, 30, -1);  // serial
    runCase(1'b0, 1'b1, 20, -1);  // serial, width pin high and ignored
    runCase(1'b1, 1'b1, 60, 29);  // mode pins toggled mid-run
    runCase(1'b1, 1'b0, 60, 21);
    runCase(1'b0, 1'b1, 40, 17);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule